// File: doc/BRIEF.md
# 2D Rectangle Copy and Fill Engine

This block moves or paints one rectangle of pixels in a linear frame memory each time it is started. The operation is described by a set of configuration inputs: a raster-operation code, a pixel data-type code, two walk-direction flags, source and destination coordinates, the rectangle size, a choice between per-surface or shared pitch and offset values, a brush colour and two palette colours. A source-copy code copies a rectangle from one place to another. Three fill codes paint the rectangle with a single colour.

Memory is reached through a synchronous port of 32-bit words. The port performs one access per cycle and has no handshake. Read data appears on the cycle after the read is issued. Pixels are packed little-endian inside words. The engine moves one byte per access, so every write uses exactly one byte lane and leaves the other bytes of the word untouched. The configuration inputs and the start pulse are plain control pins with no back-pressure. The inputs are sampled on the start cycle only. Completion is reported by a one-cycle done pulse. On success, the engine also returns updated destination coordinates and pulses a write-back strobe, so that the surrounding register file can advance its destination position for the next operation.

When a direction flag is clear, the given coordinate names the right or bottom edge of the rectangle rather than the left or top. The walk then runs from that far edge backwards, so a copy between overlapping areas is safe when the flags point away from the overlap.

Top module: `blit2d_engine`

## Requirements
- R1: `cfg_dtype` sets the bytes per pixel: 2 gives 1 byte, 3 or 4 give 2 bytes, 5 gives 3 bytes and 6 gives 4 bytes. Any other code ends the operation with `err` set and no memory write.
- R2: `cfg_rop` 0xCC copies the source rectangle. 0xF0 fills with `cfg_brush`. 0x00 fills with {0xFF, `cfg_pal0`} and 0xFF fills with {0xFF, `cfg_pal1`}. A fill writes colour byte (column byte index mod bytes per pixel). Any other code ends the operation with `err` set, no write and no coordinate write-back.
- R3: With `cfg_ltr`=1, `cfg_dst_x` is the leftmost destination column. With `cfg_ltr`=0, the leftmost column is `cfg_dst_x`+1-`cfg_width`. `cfg_ttb` treats `cfg_dst_y` and `cfg_height` the same way for the top row.
- R4: A copy finds its source left column and top row from `cfg_src_x`/`cfg_src_y` by the R3 rule, using the destination width and height.
- R5: With `cfg_own_pitch`=1, the source uses `cfg_src_pitch`/`cfg_src_ofs` and the destination uses `cfg_dst_pitch`/`cfg_dst_ofs`. With 0, both surfaces use `cfg_def_pitch`/`cfg_def_ofs`. Pitches are in bytes.
- R6: Pixel byte i of column c in row y sits at byte address offset + y*pitch + c*bpp_bytes + i. The word address is the byte address divided by 4 and the lane is byte address mod 4. Every write enables exactly one lane, and all other bytes keep their value.
- R7: The operation is aborted with `err` and no write when, for the destination (and for the source on a copy), the offset is at least the memory size in bytes or offset + (top row + height)*pitch is at least the memory size.
- R8: After a successful copy, `upd_dst_x`=`cfg_dst_x`+`cfg_width` and `upd_dst_y`=`cfg_dst_y`+`cfg_height`. After a successful fill, `upd_dst_x`=`cfg_dst_x` and `upd_dst_y`=`cfg_dst_y`+`cfg_height`. `upd_we` pulses with `done` only when `err` is 0.
- R9: A clear direction flag walks that axis from the far edge backwards. A copy whose destination lies right of, or below, an overlapping source therefore gives the same result as reading the whole source first.
- R10: `start` is accepted only while `busy` is 0. `busy` rises on the cycle after an accepted start and stays high through the single cycle in which `done` is 1. A `start` while `busy` is ignored. No memory access occurs while idle.
- R11: A width or height of zero completes with no memory write and no error, and still writes back coordinates per R8.
- R12: `err` keeps its value after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one operation (sampled when idle) |
| cfg_rop | input | 8 | Raster-operation code |
| cfg_dtype | input | 4 | Pixel data-type code |
| cfg_ltr | input | 1 | 1: x coordinates are left edges |
| cfg_ttb | input | 1 | 1: y coordinates are top edges |
| cfg_own_pitch | input | 1 | 1: per-surface pitch and offset, 0: shared |
| cfg_src_x | input | COORD_W | Source x |
| cfg_src_y | input | COORD_W | Source y |
| cfg_dst_x | input | COORD_W | Destination x |
| cfg_dst_y | input | COORD_W | Destination y |
| cfg_width | input | COORD_W | Rectangle width in pixels |
| cfg_height | input | COORD_W | Rectangle height in rows |
| cfg_src_pitch | input | PITCH_W | Source row pitch, bytes |
| cfg_dst_pitch | input | PITCH_W | Destination row pitch, bytes |
| cfg_def_pitch | input | PITCH_W | Shared row pitch, bytes |
| cfg_src_ofs | input | OFS_W | Source base byte offset |
| cfg_dst_ofs | input | OFS_W | Destination base byte offset |
| cfg_def_ofs | input | OFS_W | Shared base byte offset |
| cfg_brush | input | 32 | Brush foreground colour |
| cfg_pal0 | input | 24 | Palette colour used by 0x00 |
| cfg_pal1 | input | 24 | Palette colour used by 0xFF |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation was refused or aborted |
| upd_we | output | 1 | Write-back strobe for new coordinates |
| upd_dst_x | output | COORD_W | New destination x |
| upd_dst_y | output | COORD_W | New destination y |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_be | output | 4 | Byte-lane enables for a write |
| mem_addr | output | log2(MEM_WORDS) | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The bench targets the reverse-walk corners. One is a right-edge copy whose destination overlaps its source two pixels to the right: a design that walked forward would smear the first source bytes across the row. Another is a 3-byte pixel size, which straddles word boundaries: wrong lane arithmetic shows up there as corrupted neighbouring bytes. Refusal paths (bad data type, unknown code, and a rectangle whose end row reaches the memory size) must leave every memory word and the coordinates untouched, while a zero-width fill must complete cleanly and still advance y. A second start during a long fill must neither produce a second done pulse nor touch memory.

// File: rtl/blit2d_pkg.sv
`timescale 1ns/1ps
package blit2d_pkg;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_COPY,
    OP_FILL
  } op_kind_t;

  localparam logic [7:0] ROP_SRC_COPY = 8'hCC;
  localparam logic [7:0] ROP_PAT_COPY = 8'hF0;
  localparam logic [7:0] ROP_BLACK    = 8'h00;
  localparam logic [7:0] ROP_WHITE    = 8'hFF;

  // bytes per pixel from the data-type code, 0 marks an unusable code
  function automatic logic [2:0] px_bytes(input logic [3:0] code);
    case (code)
      4'd2:       return 3'd1;
      4'd3, 4'd4: return 3'd2;
      4'd5:       return 3'd3;
      4'd6:       return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/blit2d_setup.sv
`timescale 1ns/1ps
module blit2d_setup
  import blit2d_pkg::*;
#(
  parameter int COORD_W   = 12,
  parameter int PITCH_W   = 14,
  parameter int OFS_W     = 24,
  parameter int CALC_W    = 54,
  parameter int MEM_WORDS = 1024
) (
  input  logic [7:0]         rop,
  input  logic [3:0]         dtype,
  input  logic               ltr,
  input  logic               ttb,
  input  logic               own,
  input  logic [COORD_W-1:0] src_x,
  input  logic [COORD_W-1:0] src_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  input  logic [PITCH_W-1:0] src_pitch,
  input  logic [PITCH_W-1:0] dst_pitch,
  input  logic [PITCH_W-1:0] def_pitch,
  input  logic [OFS_W-1:0]   src_ofs,
  input  logic [OFS_W-1:0]   dst_ofs,
  input  logic [OFS_W-1:0]   def_ofs,
  input  logic [31:0]        brush,
  input  logic [23:0]        pal0,
  input  logic [23:0]        pal1,
  output op_kind_t           kind,
  output logic [2:0]         bpb,
  output logic [31:0]        colour,
  output logic [CALC_W-1:0]  dst_org,
  output logic [CALC_W-1:0]  src_org,
  output logic [CALC_W-1:0]  dpitch,
  output logic [CALC_W-1:0]  spitch,
  output logic [CALC_W-1:0]  row_bytes,
  output logic [CALC_W-1:0]  rows,
  output logic               reject,
  output logic               empty,
  output logic [COORD_W-1:0] new_x,
  output logic [COORD_W-1:0] new_y
);
  localparam logic [CALC_W-1:0] LIMIT = CALC_W'(MEM_WORDS) << 2;
  localparam logic [CALC_W-1:0] ONE   = CALC_W'(1);

  logic [CALC_W-1:0] w_c, h_c, bpb_c, d_left, d_top, s_left, s_top, d_base, s_base;
  logic              d_out, s_out;

  always_comb begin
    case (rop)
      ROP_SRC_COPY: begin kind = OP_COPY; colour = brush;          end
      ROP_PAT_COPY: begin kind = OP_FILL; colour = brush;          end
      ROP_BLACK:    begin kind = OP_FILL; colour = {8'hFF, pal0};  end
      ROP_WHITE:    begin kind = OP_FILL; colour = {8'hFF, pal1};  end
      default:      begin kind = OP_NONE; colour = brush;          end
    endcase
  end

  assign bpb       = px_bytes(dtype);
  assign w_c       = CALC_W'(width);
  assign h_c       = CALC_W'(height);
  assign bpb_c     = CALC_W'(bpb);
  assign row_bytes = w_c * bpb_c;
  assign rows      = h_c;

  // far-edge coordinates are turned into left/top edges
  assign d_left = ltr ? CALC_W'(dst_x) : CALC_W'(dst_x) + ONE - w_c;
  assign d_top  = ttb ? CALC_W'(dst_y) : CALC_W'(dst_y) + ONE - h_c;
  assign s_left = ltr ? CALC_W'(src_x) : CALC_W'(src_x) + ONE - w_c;
  assign s_top  = ttb ? CALC_W'(src_y) : CALC_W'(src_y) + ONE - h_c;

  assign dpitch = CALC_W'(own ? dst_pitch : def_pitch);
  assign spitch = CALC_W'(own ? src_pitch : def_pitch);
  assign d_base = CALC_W'(own ? dst_ofs : def_ofs);
  assign s_base = CALC_W'(own ? src_ofs : def_ofs);

  assign dst_org = d_base + d_top * dpitch + d_left * bpb_c;
  assign src_org = s_base + s_top * spitch + s_left * bpb_c;

  assign d_out = (d_base >= LIMIT) || (d_base + (d_top + h_c) * dpitch >= LIMIT);
  assign s_out = (s_base >= LIMIT) || (s_base + (s_top + h_c) * spitch >= LIMIT);

  assign reject = (kind == OP_NONE) || (bpb == 3'd0) || d_out ||
                  ((kind == OP_COPY) && s_out);
  assign empty  = (width == '0) || (height == '0);
  assign new_x  = dst_x + ((kind == OP_COPY) ? width : '0);
  assign new_y  = dst_y + height;

endmodule

// File: rtl/blit2d_walker.sv
`timescale 1ns/1ps
module blit2d_walker #(
  parameter int CALC_W = 54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              fwd_x,
  input  logic              fwd_y,
  input  logic [CALC_W-1:0] row_bytes,
  input  logic [CALC_W-1:0] rows,
  input  logic [2:0]        bpb,
  output logic [CALC_W-1:0] col,
  output logic [CALC_W-1:0] row,
  output logic [1:0]        sub,
  output logic              last
);
  localparam logic [CALC_W-1:0] ONE = CALC_W'(1);

  logic              fx, fy, act;
  logic [CALC_W-1:0] rb, nr;
  logic [1:0]        sub_top;
  logic              row_end;

  assign sub_top = 2'(bpb_q - 3'd1);
  assign row_end = fx ? (col == rb - ONE) : (col == '0);
  assign last    = row_end && (fy ? (row == nr - ONE) : (row == '0));

  logic [2:0] bpb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fx <= 1'b1; fy <= 1'b1; act <= 1'b0;
      rb <= '0; nr <= '0; bpb_q <= 3'd1;
      col <= '0; row <= '0; sub <= '0;
    end else if (load) begin
      fx    <= fwd_x;
      fy    <= fwd_y;
      rb    <= row_bytes;
      nr    <= rows;
      bpb_q <= bpb;
      act   <= 1'b1;
      col   <= fwd_x ? '0 : row_bytes - ONE;
      row   <= fwd_y ? '0 : rows - ONE;
      sub   <= fwd_x ? 2'd0 : 2'(bpb - 3'd1);
    end else if (adv) begin
      if (last) act <= 1'b0;
      if (row_end) begin
        col <= fx ? '0 : rb - ONE;
        sub <= fx ? 2'd0 : sub_top;
        row <= fy ? row + ONE : row - ONE;
      end else begin
        col <= fx ? col + ONE : col - ONE;
        if (fx) sub <= (sub == sub_top) ? 2'd0 : sub + 2'd1;
        else    sub <= (sub == 2'd0) ? sub_top : sub - 2'd1;
      end
    end
  end

  AST_WALK_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (col < rb) && (row < nr)); // R6

endmodule

// File: rtl/blit2d_engine.sv
`timescale 1ns/1ps
module blit2d_engine
  import blit2d_pkg::*;
#(
  parameter int COORD_W   = 12,
  parameter int PITCH_W   = 14,
  parameter int OFS_W     = 24,
  parameter int MEM_WORDS = 1024,
  localparam int WADDR_W  = $clog2(MEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [7:0]         cfg_rop,
  input  logic [3:0]         cfg_dtype,
  input  logic               cfg_ltr,
  input  logic               cfg_ttb,
  input  logic               cfg_own_pitch,
  input  logic [COORD_W-1:0] cfg_src_x,
  input  logic [COORD_W-1:0] cfg_src_y,
  input  logic [COORD_W-1:0] cfg_dst_x,
  input  logic [COORD_W-1:0] cfg_dst_y,
  input  logic [COORD_W-1:0] cfg_width,
  input  logic [COORD_W-1:0] cfg_height,
  input  logic [PITCH_W-1:0] cfg_src_pitch,
  input  logic [PITCH_W-1:0] cfg_dst_pitch,
  input  logic [PITCH_W-1:0] cfg_def_pitch,
  input  logic [OFS_W-1:0]   cfg_src_ofs,
  input  logic [OFS_W-1:0]   cfg_dst_ofs,
  input  logic [OFS_W-1:0]   cfg_def_ofs,
  input  logic [31:0]        cfg_brush,
  input  logic [23:0]        cfg_pal0,
  input  logic [23:0]        cfg_pal1,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               upd_we,
  output logic [COORD_W-1:0] upd_dst_x,
  output logic [COORD_W-1:0] upd_dst_y,
  output logic               mem_en,
  output logic               mem_we,
  output logic [3:0]         mem_be,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata
);
  localparam int CALC_W = OFS_W + COORD_W + PITCH_W + 4;
  localparam int ADDR_W = WADDR_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WR, S_FIN} state_t;

  state_t             state;
  op_kind_t           kind, kind_q;
  logic [2:0]         bpb;
  logic [31:0]        colour, colour_q;
  logic [CALC_W-1:0]  dst_org, src_org, dpitch, spitch, row_bytes, rows;
  logic [CALC_W-1:0]  dorg_q, sorg_q, dp_q, sp_q;
  logic               reject, empty, err_q;
  logic [COORD_W-1:0] new_x, new_y, updx_q, updy_q;
  logic [CALC_W-1:0]  w_col, w_row;
  logic [1:0]         w_sub, sel_q;
  logic               w_last, w_load, w_adv;
  logic [ADDR_W-1:0]  dbyte, sbyte;
  logic [7:0]         fill_byte, copy_byte;

  blit2d_setup #(
    .COORD_W(COORD_W), .PITCH_W(PITCH_W), .OFS_W(OFS_W),
    .CALC_W(CALC_W), .MEM_WORDS(MEM_WORDS)
  ) setup_i (
    .rop(cfg_rop), .dtype(cfg_dtype), .ltr(cfg_ltr), .ttb(cfg_ttb),
    .own(cfg_own_pitch),
    .src_x(cfg_src_x), .src_y(cfg_src_y), .dst_x(cfg_dst_x), .dst_y(cfg_dst_y),
    .width(cfg_width), .height(cfg_height),
    .src_pitch(cfg_src_pitch), .dst_pitch(cfg_dst_pitch), .def_pitch(cfg_def_pitch),
    .src_ofs(cfg_src_ofs), .dst_ofs(cfg_dst_ofs), .def_ofs(cfg_def_ofs),
    .brush(cfg_brush), .pal0(cfg_pal0), .pal1(cfg_pal1),
    .kind(kind), .bpb(bpb), .colour(colour),
    .dst_org(dst_org), .src_org(src_org), .dpitch(dpitch), .spitch(spitch),
    .row_bytes(row_bytes), .rows(rows),
    .reject(reject), .empty(empty), .new_x(new_x), .new_y(new_y)
  );

  assign w_load = (state == S_IDLE) && start && !reject && !empty;
  assign w_adv  = ((state == S_RUN) && (kind_q == OP_FILL)) || (state == S_WR);

  blit2d_walker #(.CALC_W(CALC_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .load(w_load), .adv(w_adv),
    .fwd_x(cfg_ltr), .fwd_y(cfg_ttb),
    .row_bytes(row_bytes), .rows(rows), .bpb(bpb),
    .col(w_col), .row(w_row), .sub(w_sub), .last(w_last)
  );

  assign dbyte     = ADDR_W'(dorg_q + w_row * dp_q + w_col);
  assign sbyte     = ADDR_W'(sorg_q + w_row * sp_q + w_col);
  assign fill_byte = colour_q[8*w_sub +: 8];
  assign copy_byte = mem_rdata[8*sel_q +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind_q   <= OP_NONE;
      colour_q <= '0;
      dorg_q   <= '0; sorg_q <= '0; dp_q <= '0; sp_q <= '0;
      err_q    <= 1'b0;
      updx_q   <= '0; updy_q <= '0;
      sel_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          kind_q   <= kind;
          colour_q <= colour;
          dorg_q   <= dst_org; sorg_q <= src_org;
          dp_q     <= dpitch;  sp_q   <= spitch;
          updx_q   <= new_x;   updy_q <= new_y;
          err_q    <= reject;
          state    <= (reject || empty) ? S_FIN : S_RUN;
        end
        S_RUN: begin
          if (kind_q == OP_COPY) begin
            sel_q <= sbyte[1:0];
            state <= S_WR;
          end else if (w_last) begin
            state <= S_FIN;
          end
        end
        S_WR:    state <= w_last ? S_FIN : S_RUN;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_be    = 4'b0000;
    mem_addr  = dbyte[ADDR_W-1:2];
    mem_wdata = {4{fill_byte}};
    case (state)
      S_RUN: begin
        mem_en = 1'b1;
        if (kind_q == OP_FILL) begin
          mem_we = 1'b1;
          mem_be = 4'b0001 << dbyte[1:0];
        end else begin
          mem_addr = sbyte[ADDR_W-1:2];
        end
      end
      S_WR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'b0001 << dbyte[1:0];
        mem_wdata = {4{copy_byte}};
      end
      default: ;
    endcase
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign err       = err_q;
  assign upd_we    = done && !err_q;
  assign upd_dst_x = updx_q;
  assign upd_dst_y = updy_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R10
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en); // R10
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> ($countones(mem_be) == 1)); // R6
  AST_REFUSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && err_q) |-> !mem_we); // R7
  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err)); // R12

endmodule

// File: tb/blit2d_engine_tb_top.sv
`timescale 1ns/1ps
module blit2d_engine_tb_top;
  localparam int MEM_WORDS = 1024;
  localparam int MEMB      = MEM_WORDS * 4;
  localparam int DEF_P = 64, SRC_P = 40, DST_P = 48;
  localparam int DEF_O = 20, SRC_O = 1100, DST_O = 2000;
  localparam logic [31:0] BRUSH = 32'hA1B2C3D4;
  localparam logic [23:0] PAL0  = 24'h102030;
  localparam logic [23:0] PAL1  = 24'hE0F0A0;

  typedef struct packed {
    logic [7:0]  rop;
    logic [3:0]  dt;
    logic        fx, fy, own;
    logic [11:0] sx, sy, dx, dy, w, h;
    logic        xerr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'hCC, 4'd2, 1'b1, 1'b1, 1'b1, 12'd2,  12'd1,  12'd5,  12'd3,  12'd4, 12'd3, 1'b0},
    '{8'hCC, 4'd3, 1'b0, 1'b1, 1'b1, 12'd9,  12'd2,  12'd10, 12'd0,  12'd3, 12'd4, 1'b0},
    '{8'hCC, 4'd5, 1'b1, 1'b1, 1'b0, 12'd1,  12'd10, 12'd6,  12'd20, 12'd4, 12'd2, 1'b0},
    '{8'hCC, 4'd6, 1'b0, 1'b0, 1'b1, 12'd8,  12'd7,  12'd9,  12'd12, 12'd3, 12'd3, 1'b0},
    '{8'hF0, 4'd4, 1'b1, 1'b1, 1'b1, 12'd0,  12'd0,  12'd3,  12'd4,  12'd5, 12'd2, 1'b0},
    '{8'h00, 4'd6, 1'b1, 1'b0, 1'b0, 12'd0,  12'd0,  12'd2,  12'd30, 12'd3, 12'd3, 1'b0},
    '{8'hFF, 4'd5, 1'b0, 1'b1, 1'b1, 12'd0,  12'd0,  12'd7,  12'd1,  12'd4, 12'd2, 1'b0},
    '{8'hCC, 4'd7, 1'b1, 1'b1, 1'b1, 12'd1,  12'd1,  12'd2,  12'd2,  12'd2, 12'd2, 1'b1},
    '{8'h66, 4'd2, 1'b1, 1'b1, 1'b1, 12'd1,  12'd1,  12'd2,  12'd2,  12'd2, 12'd2, 1'b1},
    '{8'hF0, 4'd2, 1'b1, 1'b1, 1'b0, 12'd0,  12'd0,  12'd0,  12'd60, 12'd2, 12'd5, 1'b1},
    '{8'hCC, 4'd2, 1'b0, 1'b1, 1'b0, 12'd10, 12'd40, 12'd12, 12'd40, 12'd8, 12'd2, 1'b0},
    '{8'hF0, 4'd2, 1'b1, 1'b1, 1'b0, 12'd0,  12'd0,  12'd4,  12'd5,  12'd0, 12'd3, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] rop; logic [3:0] dtype; logic ltr, ttb, own;
  logic [11:0] sx, sy, dx, dy, wd, ht;
  logic busy, done, err, upd_we, mem_en, mem_we;
  logic [11:0] upd_x, upd_y;
  logic [3:0]  mem_be;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] mem  [MEM_WORDS];
  logic [7:0]  refm [MEMB];
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  blit2d_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_rop(rop), .cfg_dtype(dtype), .cfg_ltr(ltr), .cfg_ttb(ttb), .cfg_own_pitch(own),
    .cfg_src_x(sx), .cfg_src_y(sy), .cfg_dst_x(dx), .cfg_dst_y(dy),
    .cfg_width(wd), .cfg_height(ht),
    .cfg_src_pitch(14'(SRC_P)), .cfg_dst_pitch(14'(DST_P)), .cfg_def_pitch(14'(DEF_P)),
    .cfg_src_ofs(24'(SRC_O)), .cfg_dst_ofs(24'(DST_O)), .cfg_def_ofs(24'(DEF_O)),
    .cfg_brush(BRUSH), .cfg_pal0(PAL0), .cfg_pal1(PAL1),
    .busy(busy), .done(done), .err(err), .upd_we(upd_we),
    .upd_dst_x(upd_x), .upd_dst_y(upd_y),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] patb(input int i);
    return 8'(i * 37 + 11) ^ 8'(i >> 7);
  endfunction

  // word memory, one access per cycle, read data one cycle later
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++)
        mem[i] <= {patb(4*i+3), patb(4*i+2), patb(4*i+1), patb(4*i)};
    end else if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
      mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string vec_req(input int i);
    case (i)
      0: return "R6";  1: return "R3";  2: return "R5";  3: return "R4";
      4, 5, 6, 8: return "R2";  7: return "R1";  9: return "R7";
      10: return "R9"; default: return "R11";
    endcase
  endfunction

  // reference: buffered byte-wise model built from the requirements
  task automatic ref_apply(input vec_t v, output logic [11:0] ex, output logic [11:0] ey);
    int bpb, dl, dtop, sl, st, dp, sp, db, sb, rowb;
    logic [31:0] colr;
    bit cp, fl, bad;
    logic [7:0] tmp [MEMB];
    case (v.dt)
      4'd2: bpb = 1; 4'd3, 4'd4: bpb = 2; 4'd5: bpb = 3; 4'd6: bpb = 4; default: bpb = 0;
    endcase
    cp   = (v.rop == 8'hCC);
    fl   = (v.rop == 8'hF0) || (v.rop == 8'h00) || (v.rop == 8'hFF);
    colr = (v.rop == 8'hF0) ? BRUSH : (v.rop == 8'h00) ? {8'hFF, PAL0} : {8'hFF, PAL1};
    dl   = v.fx ? int'(v.dx) : int'(v.dx) + 1 - int'(v.w);
    dtop = v.fy ? int'(v.dy) : int'(v.dy) + 1 - int'(v.h);
    sl   = v.fx ? int'(v.sx) : int'(v.sx) + 1 - int'(v.w);
    st   = v.fy ? int'(v.sy) : int'(v.sy) + 1 - int'(v.h);
    dp = v.own ? DST_P : DEF_P;  db = v.own ? DST_O : DEF_O;
    sp = v.own ? SRC_P : DEF_P;  sb = v.own ? SRC_O : DEF_O;
    bad = (bpb == 0) || !(cp || fl) || (db >= MEMB) ||
          (db + (dtop + int'(v.h)) * dp >= MEMB) ||
          (cp && ((sb >= MEMB) || (sb + (st + int'(v.h)) * sp >= MEMB)));
    ex = cp ? v.dx + v.w : v.dx;
    ey = v.dy + v.h;
    if (!bad) begin
      rowb = int'(v.w) * bpb;
      if (cp) begin
        for (int r = 0; r < int'(v.h); r++)
          for (int c = 0; c < rowb; c++)
            tmp[r*rowb + c] = refm[sb + (st + r) * sp + sl * bpb + c];
        for (int r = 0; r < int'(v.h); r++)
          for (int c = 0; c < rowb; c++)
            refm[db + (dtop + r) * dp + dl * bpb + c] = tmp[r*rowb + c];
      end else begin
        for (int r = 0; r < int'(v.h); r++)
          for (int c = 0; c < rowb; c++)
            refm[db + (dtop + r) * dp + dl * bpb + c] = colr[8*(c % bpb) +: 8];
      end
    end
  endtask

  task automatic drive(input vec_t v);
    rop = v.rop; dtype = v.dt; ltr = v.fx; ttb = v.fy; own = v.own;
    sx = v.sx; sy = v.sy; dx = v.dx; dy = v.dy; wd = v.w; ht = v.h;
  endtask

  task automatic check_mem(input string req);
    int nbad = 0;
    for (int i = 0; i < MEM_WORDS; i++)
      if (mem[i] !== {refm[4*i+3], refm[4*i+2], refm[4*i+1], refm[4*i]}) nbad++;
    chk(nbad == 0, req, "differing memory words", nbad, 0);
  endtask

  // start pulse at a negedge, then wait for done; returns outputs in the done cycle
  task automatic run_op(output bit got, output logic e, output logic uw,
                        output logic [11:0] ux, output logic [11:0] uy);
    got = 0; e = 0; uw = 0; ux = '0; uy = '0;
    start = 1'b1;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin
        got = 1; e = err; uw = upd_we; ux = upd_x; uy = upd_y;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit got; logic e, uw; logic [11:0] ux, uy, ex, ey;
    for (int i = 0; i < MEMB; i++) refm[i] = patb(i);
    drive(VECS[0]);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, R10
    chk(busy == 0,   "R10", "busy after reset",   busy, 0);
    chk(done == 0,   "R10", "done after reset",   done, 0);
    chk(err == 0,    "R12", "err after reset",    err, 0);
    chk(upd_we == 0, "R8",  "upd_we after reset", upd_we, 0);
    chk(mem_en == 0, "R10", "mem_en while idle",  mem_en, 0);
    check_mem("R6");

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      ref_apply(VECS[i], ex, ey);
      run_op(got, e, uw, ux, uy);
      chk(got, "R10", $sformatf("done seen vec %0d", i), got, 1);
      chk(e == VECS[i].xerr, vec_req(i), $sformatf("err vec %0d", i), e, VECS[i].xerr);
      check_mem(vec_req(i));
      if (!VECS[i].xerr) begin
        chk(uw == 1,  "R8", $sformatf("upd_we vec %0d", i), uw, 1);
        chk(ux == ex, "R8", $sformatf("upd_dst_x vec %0d", i), ux, ex);
        chk(uy == ey, "R8", $sformatf("upd_dst_y vec %0d", i), uy, ey);
      end else begin
        chk(uw == 0, "R8", $sformatf("no write-back vec %0d", i), uw, 0);
      end
      @(negedge clk);
      chk(done == 0, "R10", $sformatf("done single cycle vec %0d", i), done, 0);
      if (i == 9) begin
        repeat (3) @(negedge clk);
        chk(err == 1, "R12", "err held after refused op", err, 1);
      end
    end
    chk(err == 0, "R12", "err cleared by later good op", err, 0);

    // start while busy is ignored, R10
    begin
      vec_t a, b; int ndone = 0;
      a = '{8'hF0, 4'd2, 1'b1, 1'b1, 1'b0, 12'd0, 12'd0, 12'd0, 12'd45, 12'd10, 12'd4, 1'b0};
      b = '{8'h00, 4'd6, 1'b1, 1'b1, 1'b0, 12'd0, 12'd0, 12'd0, 12'd50, 12'd2,  12'd2, 1'b0};
      drive(a);
      ref_apply(a, ex, ey);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      chk(busy == 1, "R10", "busy during long fill", busy, 1);
      drive(b);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < 200; n++) begin
        if (done) ndone++;
        @(negedge clk);
      end
      chk(ndone == 1, "R10", "done pulses for busy-start case", ndone, 1);
      chk(busy == 0, "R10", "idle after busy-start case", busy, 0);
      check_mem("R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule